// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Conditioner

This block sits in the receive-to-system path of an E1 framer. It takes a byte-serial stream of 32-timeslot E1 frames and rewrites the stream on its way to the system side. The stream arrives with a valid strobe and the index of the timeslot that each byte belongs to. Four per-link control bits select the changes, and the framer supplies one status bit that reports loss of timeslot-16 multiframe alignment.

A line-wide alarm can replace every timeslot with all ones. Two alarm controls, one forced and one that depends on the alignment status, replace only the signaling timeslot (index 16) with all ones. A fill control turns any all-zero signaling nibble in timeslot 16 into all ones, and it treats each nibble on its own. The conditioned byte, its valid flag and its timeslot index leave the block one clock cycle after they enter. Control and status inputs act on the byte that is presented in the same cycle. Nothing waits for a frame boundary.

Top module: `sig16_conditioner`

## Requirements
- R1: While reset is asserted, out_vld, out_byte and out_slot are all 0. With every control input at 0, each valid byte reaches out_byte unchanged.
- R2: out_vld and out_slot repeat in_vld and in_slot one cycle later, and out_byte has the same one-cycle latency. When in_vld is 0, out_vld goes to 0 and out_byte and out_slot keep their previous values.
- R3: When ctl_force_sig_ais is 1, a valid byte with in_slot equal to 16 leaves as 0xFF.
- R4: When ctl_auto_sig_ais is 1 and st_mf_lost is 1 in the cycle of a timeslot-16 byte, that byte leaves as 0xFF. When st_mf_lost is 0, the byte is not forced by this control.
- R5: When ctl_line_ais is 1, every valid byte leaves as 0xFF, whatever its timeslot. This control takes priority over every other control.
- R6: When ctl_nib_fill is 1 and neither alarm in R3 nor in R4 forces the byte, a timeslot-16 byte has bits 7:4 replaced by 1111 if they are 0000, and bits 3:0 replaced by 1111 if they are 0000. Each nibble is judged separately, and any nibble that is not zero passes unchanged.
- R7: Bytes with in_slot other than 16 are never changed by ctl_force_sig_ais, ctl_auto_sig_ais, ctl_nib_fill or st_mf_lost.
- R8: A change of a control or status input acts from the next byte presented, including a change in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_slot | input | 5 | Timeslot index of the input byte (0 to 31) |
| ctl_force_sig_ais | input | 1 | Force timeslot 16 to all ones |
| ctl_auto_sig_ais | input | 1 | Force timeslot 16 to all ones while multiframe alignment is lost |
| ctl_line_ais | input | 1 | Force every timeslot to all ones |
| ctl_nib_fill | input | 1 | Replace zero nibbles of timeslot 16 with all ones |
| st_mf_lost | input | 1 | Timeslot-16 multiframe alignment lost |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Conditioned byte |
| out_slot | output | 5 | Timeslot index of the output byte |

## Verification
The nibble fill and the timeslot-16 alarm can act on the same byte in the same cycle. Line AIS can also land on a timeslot-16 byte that another rule is already changing. The bench provokes these clashes by sweeping all 256 byte values in timeslot 16 against all 16 control combinations and both status values. It judges each output against a priority model: line AIS first, then either timeslot-16 alarm, then fill. A separate frame toggles the controls and the status between neighbouring timeslots, which shows that each change takes effect at the byte where it happens.

// File: rtl/sig16_pkg.sv
package sig16_pkg;
   typedef struct packed {
      logic line_ais;
      logic force_sig;
      logic auto_sig;
      logic nib_fill;
   } sig16_ctl_t;
endpackage

// File: rtl/sig16_slot_match.sv
module sig16_slot_match #(
   parameter int SLOT_W   = 5,
   parameter int SIG_SLOT = 16
) (
   input  logic [SLOT_W-1:0] slot,
   output logic              hit
);
   localparam logic [SLOT_W-1:0] SigIdx = SLOT_W'(SIG_SLOT);
   assign hit = (slot == SigIdx);
endmodule

// File: rtl/sig16_nibble_fill.sv
module sig16_nibble_fill #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NibN = DATA_W / 4;

   for (genvar g = 0; g < NibN; g++) begin : g_nib
      assign dout[g*4 +: 4] = (din[g*4 +: 4] == 4'h0) ? 4'hF : din[g*4 +: 4];
   end
endmodule

// File: rtl/sig16_byte_rule.sv
module sig16_byte_rule
   import sig16_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] din,
   input  logic              sig_hit,
   input  sig16_ctl_t        ctl,
   input  logic              mf_lost,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] filled;
   logic              all_ones;
   logic              do_fill;

   sig16_nibble_fill #(.DATA_W(DATA_W)) u_fill (
      .din  (din),
      .dout (filled)
   );

   always_comb begin
      all_ones = ctl.line_ais
               | (sig_hit & (ctl.force_sig | (ctl.auto_sig & mf_lost)));
      do_fill  = sig_hit & ctl.nib_fill;
      if (all_ones)     dout = '1;
      else if (do_fill) dout = filled;
      else              dout = din;
   end
endmodule

// File: rtl/sig16_out_stage.sv
module sig16_out_stage #(
   parameter int DATA_W = 8,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_vld,
   input  logic [DATA_W-1:0] d_byte,
   input  logic [SLOT_W-1:0] d_slot,
   output logic              q_vld,
   output logic [DATA_W-1:0] q_byte,
   output logic [SLOT_W-1:0] q_slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_byte <= '0;
         q_slot <= '0;
      end else begin
         q_vld <= d_vld;
         if (d_vld) begin
            q_byte <= d_byte;
            q_slot <= d_slot;
         end
      end
   end
endmodule

// File: rtl/sig16_conditioner.sv
module sig16_conditioner
   import sig16_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SLOT_W    = 5,
   parameter int NUM_SLOTS = 32,
   parameter int SIG_SLOT  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_byte,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic              ctl_force_sig_ais,
   input  logic              ctl_auto_sig_ais,
   input  logic              ctl_line_ais,
   input  logic              ctl_nib_fill,
   input  logic              st_mf_lost,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_byte,
   output logic [SLOT_W-1:0] out_slot
);
   localparam int SlotSpan = 1 << SLOT_W;

   if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 4");
   end
   if (NUM_SLOTS > SlotSpan || SIG_SLOT >= NUM_SLOTS) begin : g_bad_slot
      $error("slot parameters out of range");
   end

   sig16_ctl_t        ctl;
   logic              sig_hit;
   logic [DATA_W-1:0] cond_byte;

   assign ctl = '{line_ais:  ctl_line_ais,
                  force_sig: ctl_force_sig_ais,
                  auto_sig:  ctl_auto_sig_ais,
                  nib_fill:  ctl_nib_fill};

   sig16_slot_match #(.SLOT_W(SLOT_W), .SIG_SLOT(SIG_SLOT)) u_match (
      .slot (in_slot),
      .hit  (sig_hit)
   );

   sig16_byte_rule #(.DATA_W(DATA_W)) u_rule (
      .din     (in_byte),
      .sig_hit (sig_hit),
      .ctl     (ctl),
      .mf_lost (st_mf_lost),
      .dout    (cond_byte)
   );

   sig16_out_stage #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_vld  (in_vld),
      .d_byte (cond_byte),
      .d_slot (in_slot),
      .q_vld  (out_vld),
      .q_byte (out_byte),
      .q_slot (out_slot)
   );
endmodule

// File: rtl/sig16_conditioner_chk.sv
module sig16_conditioner_chk #(
   parameter int DATA_W   = 8,
   parameter int SLOT_W   = 5,
   parameter int SIG_SLOT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_byte,
   input logic [SLOT_W-1:0] in_slot,
   input logic              ctl_force_sig_ais,
   input logic              ctl_auto_sig_ais,
   input logic              ctl_line_ais,
   input logic              ctl_nib_fill,
   input logic              st_mf_lost,
   input logic              out_vld,
   input logic [DATA_W-1:0] out_byte,
   input logic [SLOT_W-1:0] out_slot
);
   localparam logic [SLOT_W-1:0] SigIdx = SLOT_W'(SIG_SLOT);

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == $past(in_vld) || !$past(rst_n) ? 1'b1 : 1'b0);

   // R2
   bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld && $stable(out_byte) && $stable(out_slot));

   // R2
   slot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld && out_slot == $past(in_slot));

   // R5
   line_ais_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && ctl_line_ais |=> out_byte == '1);

   // R3
   force_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && in_slot == SigIdx && ctl_force_sig_ais |=> out_byte == '1);

   // R4
   auto_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && in_slot == SigIdx && ctl_auto_sig_ais && st_mf_lost |=> out_byte == '1);

   // R7
   other_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && in_slot != SigIdx && !ctl_line_ais |=> out_byte == $past(in_byte));

   // R6
   nib_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && in_slot == SigIdx && ctl_nib_fill && !ctl_line_ais
      |=> out_byte[DATA_W-1 -: 4] != 4'h0 && out_byte[3:0] != 4'h0);
endmodule

bind sig16_conditioner sig16_conditioner_chk #(
   .DATA_W(DATA_W), .SLOT_W(SLOT_W), .SIG_SLOT(SIG_SLOT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .in_slot(in_slot),
   .ctl_force_sig_ais(ctl_force_sig_ais), .ctl_auto_sig_ais(ctl_auto_sig_ais),
   .ctl_line_ais(ctl_line_ais), .ctl_nib_fill(ctl_nib_fill), .st_mf_lost(st_mf_lost),
   .out_vld(out_vld), .out_byte(out_byte), .out_slot(out_slot)
);

// File: tb/tb_sig16_conditioner.sv
`timescale 1ns/1ps
module tb_sig16_conditioner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic [4:0] in_slot = 5'd0;
   logic       c_force = 1'b0, c_auto = 1'b0, c_line = 1'b0, c_fill = 1'b0;
   logic       st_lost = 1'b0;
   logic       out_vld;
   logic [7:0] out_byte;
   logic [4:0] out_slot;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic       pend = 1'b0;
   logic       e_vld = 1'b0;
   logic [7:0] e_byte = 8'h00;
   logic [4:0] e_slot = 5'd0;
   string      e_tag = "R1";

   always #10 clk = ~clk;

   sig16_conditioner dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte), .in_slot(in_slot),
      .ctl_force_sig_ais(c_force), .ctl_auto_sig_ais(c_auto),
      .ctl_line_ais(c_line), .ctl_nib_fill(c_fill), .st_mf_lost(st_lost),
      .out_vld(out_vld), .out_byte(out_byte), .out_slot(out_slot)
   );

   function automatic logic [3:0] fill4(input logic [3:0] n);
      return (n == 4'h0) ? 4'hF : n;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_pending();
      if (pend) begin
         check("R2", "out_vld", int'(out_vld), int'(e_vld));
         check("R2", "out_slot", int'(out_slot), int'(e_slot));
         check(e_vld ? e_tag : "R2", "out_byte", int'(out_byte), int'(e_byte));
      end
   endtask

   // ctl bits: [3] line AIS, [2] forced TS16 AIS, [1] automatic TS16 AIS, [0] nibble fill
   task automatic apply(input logic v, input logic [7:0] b, input logic [4:0] s,
                        input logic [3:0] c, input logic lost, input string tag_ovr);
      string t;
      logic [7:0] x;
      @(negedge clk);
      compare_pending();
      in_vld = v; in_byte = b; in_slot = s;
      c_line = c[3]; c_force = c[2]; c_auto = c[1]; c_fill = c[0]; st_lost = lost;
      if (c[3]) begin
         x = 8'hFF; t = "R5";
      end else if (s == 5'd16 && c[2]) begin
         x = 8'hFF; t = "R3";
      end else if (s == 5'd16 && c[1] && lost) begin
         x = 8'hFF; t = "R4";
      end else if (s == 5'd16 && c[0]) begin
         x = {fill4(b[7:4]), fill4(b[3:0])}; t = "R6";
      end else if (s != 5'd16 && c != 4'd0) begin
         x = b; t = "R7";
      end else begin
         x = b; t = (s == 5'd16 && c[1]) ? "R4" : "R1";
      end
      if (tag_ovr != "") t = tag_ovr;
      pend = 1'b1;
      e_vld = v;
      if (v) begin
         e_byte = x; e_slot = s; e_tag = t;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      in_vld = 1'b1; in_byte = 8'hAB; in_slot = 5'd16; c_line = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R1", "reset out_vld", int'(out_vld), 0);
         check("R1", "reset out_byte", int'(out_byte), 0);
         check("R1", "reset out_slot", int'(out_slot), 0);
      end
      c_line = 1'b0;
      rst_n = 1'b1;

      // R1: pass-through with every control at 0
      for (int s = 0; s < 32; s++)
         apply(1'b1, 8'((s * 7 + 3) & 8'hF0), 5'(s), 4'd0, 1'b0, "R1");

      // Timeslot 16: every byte against every control combination and status
      for (int c = 0; c < 16; c++)
         for (int l = 0; l < 2; l++)
            for (int b = 0; b < 256; b++)
               apply(1'b1, 8'(b), 5'd16, 4'(c), 1'(l), "");

      // R7: other timeslots under every control combination
      for (int s = 0; s < 32; s++) begin
         if (s == 16) continue;
         for (int c = 0; c < 16; c++)
            for (int l = 0; l < 2; l++) begin
               apply(1'b1, 8'h00, 5'(s), 4'(c), 1'(l), "");
               apply(1'b1, 8'h0F, 5'(s), 4'(c), 1'(l), "");
               apply(1'b1, 8'hF0, 5'(s), 4'(c), 1'(l), "");
               apply(1'b1, 8'(s * 9 + c), 5'(s), 4'(c), 1'(l), "");
            end
      end

      // R2: bubbles between bytes hold the output
      for (int k = 0; k < 64; k++) begin
         apply(1'b1, 8'(k * 37), 5'(k % 32), 4'(k % 16), 1'(k % 2), "");
         apply(1'b0, 8'(~k), 5'(31 - (k % 32)), 4'(15 - (k % 16)), 1'b1, "R2");
         if (k % 3 == 0)
            apply(1'b0, 8'h00, 5'd16, 4'hF, 1'b1, "R2");
      end

      // R8: controls and status change mid-frame
      for (int r = 0; r < 2; r++)
         for (int s = 0; s < 32; s++) begin
            if (s == 16)
               apply(1'b1, 8'h00, 5'(s), r == 0 ? 4'b0100 : 4'b0010, 1'b1, "R8");
            else if (s == 17)
               apply(1'b1, 8'h00, 5'(s), 4'b0001, 1'b0, "R8");
            else
               apply(1'b1, 8'(s), 5'(s), 4'd0, 1'b0, "R8");
         end
      apply(1'b1, 8'h00, 5'd16, 4'b0010, 1'b0, "R8");
      apply(1'b1, 8'h00, 5'd16, 4'b0010, 1'b1, "R8");
      apply(1'b1, 8'h00, 5'd16, 4'b0001, 1'b1, "R8");
      apply(1'b1, 8'h30, 5'd16, 4'b1000, 1'b0, "R8");

      @(negedge clk);
      compare_pending();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule